// File: doc/BRIEF.md
# Programmable Address Window Translator

This block sits between a processor's address output and its system interconnect. It holds fourteen programmable decode windows and decides which bus target a 32-bit address belongs to. Each window is aligned to 64 KB and sized in multiples of 64 KB. A window is described by a control word, a base word and, for the lower windows only, a pair of remap words. Software sets up the windows through a plain register write/read port.

On every clock the block compares the presented lookup address with all enabled windows. One clock later it reports whether a window was hit, the target ID and attribute byte of the winning window, and the translated address. When several windows overlap, the lowest-numbered one wins. When no window matches, a miss flag is raised and every result field is zero. The first eight windows can move the address into a different region. The remaining windows forward the address unchanged.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window register reads as zero, `lk_hit` is 0, `lk_miss` is 1, and all result fields are zero.
- R2: Register offsets on `cfg_addr`: window w below 8 is at w*16, and window w from 8 to 13 is at 0x900+(w-8)*16. Inside a window, offset 0x0 is control, 0x4 is base, 0x8 is remap low and 0xC is remap high.
- R3: The control word holds the size-minus-one value in bits 31:16, the attribute in bits 15:8, the target in bits 7:4 and the enable in bit 0. Its bits 3:1 read as zero. Base and remap low keep only bits 31:16, and their bits 15:0 read as zero. Remap high keeps all 32 bits.
- R4: Windows 8 to 13 have no remap registers: writes to those offsets are ignored and reads return zero. Offsets that name no register, and offsets with `cfg_addr[1:0]` not zero, also read zero and ignore writes.
- R5: An address hits an enabled window when `addr[31:16] & ~size_m1` equals `base[31:16] & ~size_m1`.
- R6: A window whose enable bit is 0 never hits. This includes a window whose control word was written with zero.
- R7: On a hit in windows 0 to 7, the upper half of the result is `(remap_lo[31:16] & ~size_m1) | (addr[31:16] & size_m1)`. Remap high has no effect on the result.
- R8: On a hit in windows 8 to 13, the result address equals the lookup address.
- R9: When several windows hit, the lowest-numbered window supplies the target, the attribute and the translation.
- R10: On a miss, `lk_miss` is 1, `lk_hit` is 0, and the target, attribute and result address are all zero.
- R11: Results are registered. They show the lookup address and register contents as they stood at the previous rising clock edge, and they hold until the next edge.
- R12: On a hit, the low 16 bits of the result address equal the low 16 bits of the lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Registered: a window matched |
| lk_miss | output | 1 | Registered: no window matched |
| lk_target | output | 4 | Registered target ID of the winning window |
| lk_attr | output | 8 | Registered attribute byte of the winning window |
| lk_xaddr | output | 32 | Registered translated address |

## Verification
Register reads are combinational, so each readback is sampled shortly after `cfg_addr` is driven, within the same low clock phase. A write takes effect at the rising edge it is presented on. Lookup results pass through exactly one register. The bench therefore drives `lk_addr` on a falling edge and compares the outputs at the next falling edge. It also checks just after the address changes that the outputs still show the previous result. A write and a lookup are never placed in the same cycle, so the expected value always comes from a settled model.

// File: rtl/adw_pkg.sv
package adw_pkg;

   localparam int DW     = 32;
   localparam int GRAN_W = 16;
   localparam int UP_W   = DW - GRAN_W;
   localparam int ATTR_W = 8;
   localparam int TGT_W  = 4;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RMLO = 2'd2,
      SEL_RMHI = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [UP_W-1:0]   size_m1;
      logic [ATTR_W-1:0] attr;
      logic [TGT_W-1:0]  tgt;
      logic              en;
   } win_ctrl_t;

   function automatic logic [DW-1:0] pack_ctrl(input win_ctrl_t c);
      return {c.size_m1, c.attr, c.tgt, 3'b000, c.en};
   endfunction

   function automatic win_ctrl_t unpack_ctrl(input logic [DW-1:0] d);
      win_ctrl_t c;
      c.size_m1 = d[DW-1:GRAN_W];
      c.attr    = d[15:8];
      c.tgt     = d[7:4];
      c.en      = d[0];
      return c;
   endfunction

endpackage

// File: rtl/adw_regfile.sv
module adw_regfile
   import adw_pkg::*;
#(
   parameter int          NUM_WIN     = 14,
   parameter int          NUM_REMAP   = 8,
   parameter int          CFG_AW      = 12,
   parameter int unsigned HI_BANK_OFS = 32'h900
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [DW-1:0]         cfg_wdata,
   output logic [DW-1:0]         cfg_rdata,
   output win_ctrl_t             ctrl_o [NUM_WIN],
   output logic [UP_W-1:0]       base_o [NUM_WIN],
   output logic [UP_W-1:0]       xsrc_o [NUM_WIN]
);

   localparam int SLOT_W = CFG_AW - 4;
   localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int NUM_HI = NUM_WIN - NUM_REMAP;
   localparam logic [SLOT_W-1:0] HI_SLOT = SLOT_W'(HI_BANK_OFS >> 4);

   logic [SLOT_W-1:0] slot;
   logic [SLOT_W-1:0] hi_rel;
   logic              acc_ok;
   logic [IW-1:0]     acc_idx;
   reg_sel_e          sel;
   logic [DW-1:0]     rd_win [NUM_WIN];

   assign slot   = cfg_addr[CFG_AW-1:4];
   assign hi_rel = slot - HI_SLOT;
   assign sel    = reg_sel_e'(cfg_addr[3:2]);

   // Decode the byte offset into a window index.
   always_comb begin
      acc_ok  = 1'b0;
      acc_idx = '0;
      if (cfg_addr[1:0] == 2'b00) begin
         if (int'(slot) < NUM_REMAP) begin
            acc_ok  = 1'b1;
            acc_idx = IW'(slot);
         end else if ((slot >= HI_SLOT) && (int'(hi_rel) < NUM_HI)) begin
            acc_ok  = 1'b1;
            acc_idx = IW'(hi_rel) + IW'(NUM_REMAP);
         end
      end
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic      wr_w;
      win_ctrl_t ctrl_r;
      logic [UP_W-1:0] base_r;

      assign wr_w = cfg_we && acc_ok && (acc_idx == IW'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_r <= '0;
            base_r <= '0;
         end else if (wr_w) begin
            if (sel == SEL_CTRL) ctrl_r <= unpack_ctrl(cfg_wdata);
            if (sel == SEL_BASE) base_r <= cfg_wdata[DW-1:GRAN_W];
         end
      end

      assign ctrl_o[w] = ctrl_r;
      assign base_o[w] = base_r;

      if (w < NUM_REMAP) begin : g_remap
         logic [UP_W-1:0] rmlo_r;
         logic [DW-1:0]   rmhi_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rmlo_r <= '0;
               rmhi_r <= '0;
            end else if (wr_w) begin
               if (sel == SEL_RMLO) rmlo_r <= cfg_wdata[DW-1:GRAN_W];
               if (sel == SEL_RMHI) rmhi_r <= cfg_wdata;
            end
         end

         assign xsrc_o[w] = rmlo_r;

         always_comb begin
            unique case (sel)
               SEL_CTRL: rd_win[w] = pack_ctrl(ctrl_r);
               SEL_BASE: rd_win[w] = {base_r, {GRAN_W{1'b0}}};
               SEL_RMLO: rd_win[w] = {rmlo_r, {GRAN_W{1'b0}}};
               SEL_RMHI: rd_win[w] = rmhi_r;
               default:  rd_win[w] = '0;
            endcase
         end
      end else begin : g_fixed
         // A fixed window translates through its own base: on a hit the
         // unmasked bits already equal the address, so the address passes.
         assign xsrc_o[w] = base_r;

         always_comb begin
            unique case (sel)
               SEL_CTRL: rd_win[w] = pack_ctrl(ctrl_r);
               SEL_BASE: rd_win[w] = {base_r, {GRAN_W{1'b0}}};
               default:  rd_win[w] = '0;
            endcase
         end
      end
   end

   assign cfg_rdata = acc_ok ? rd_win[acc_idx] : '0;

endmodule

// File: rtl/adw_match.sv
module adw_match
   import adw_pkg::*;
(
   input  win_ctrl_t        ctrl,
   input  logic [UP_W-1:0]  base_up,
   input  logic [UP_W-1:0]  xsrc_up,
   input  logic [UP_W-1:0]  addr_up,
   output logic             hit,
   output logic [UP_W-1:0]  out_up
);

   logic [UP_W-1:0] keep;

   assign keep   = ~ctrl.size_m1;
   assign hit    = ctrl.en && ((addr_up & keep) == (base_up & keep));
   assign out_up = (xsrc_up & keep) | (addr_up & ctrl.size_m1);

endmodule

// File: rtl/adw_prio.sv
module adw_prio #(
   parameter int NUM_WIN = 14,
   localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   output logic               any_hit,
   output logic [IW-1:0]      sel_idx
);

   // Scan from the top so the lowest set index is the one left standing.
   always_comb begin
      sel_idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel_idx = IW'(i);
      end
   end

   assign any_hit = |hit_vec;

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
   import adw_pkg::*;
#(
   parameter int          NUM_WIN     = 14,
   parameter int          NUM_REMAP   = 8,
   parameter int          CFG_AW      = 12,
   parameter int unsigned HI_BANK_OFS = 32'h900
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [11:0]       cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [31:0]       lk_addr,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [3:0]        lk_target,
   output logic [7:0]        lk_attr,
   output logic [31:0]       lk_xaddr
);

   localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (NUM_REMAP > NUM_WIN) begin : g_bad_remap
      $error("NUM_REMAP exceeds NUM_WIN");
   end
   if (CFG_AW != 12) begin : g_bad_aw
      $error("CFG_AW must match the 12-bit port");
   end
   if ((HI_BANK_OFS % 16) != 0) begin : g_bad_align
      $error("HI_BANK_OFS must be 16-byte aligned");
   end
   if (NUM_REMAP * 16 > HI_BANK_OFS) begin : g_bad_overlap
      $error("low bank overlaps the high bank");
   end
   if (HI_BANK_OFS + (NUM_WIN - NUM_REMAP) * 16 > (1 << CFG_AW)) begin : g_bad_span
      $error("high bank exceeds the register space");
   end

   win_ctrl_t          ctrl_a [NUM_WIN];
   logic [UP_W-1:0]    base_a [NUM_WIN];
   logic [UP_W-1:0]    xsrc_a [NUM_WIN];
   logic [UP_W-1:0]    up_a   [NUM_WIN];
   logic [NUM_WIN-1:0] hit_vec;
   logic               any_hit;
   logic [IW-1:0]      sel_idx;

   adw_regfile #(
      .NUM_WIN     (NUM_WIN),
      .NUM_REMAP   (NUM_REMAP),
      .CFG_AW      (CFG_AW),
      .HI_BANK_OFS (HI_BANK_OFS)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .ctrl_o    (ctrl_a),
      .base_o    (base_a),
      .xsrc_o    (xsrc_a)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      adw_match match_i (
         .ctrl    (ctrl_a[w]),
         .base_up (base_a[w]),
         .xsrc_up (xsrc_a[w]),
         .addr_up (lk_addr[DW-1:GRAN_W]),
         .hit     (hit_vec[w]),
         .out_up  (up_a[w])
      );
   end

   adw_prio #(.NUM_WIN(NUM_WIN)) prio_i (
      .hit_vec (hit_vec),
      .any_hit (any_hit),
      .sel_idx (sel_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_hit    <= 1'b0;
         lk_miss   <= 1'b1;
         lk_target <= '0;
         lk_attr   <= '0;
         lk_xaddr  <= '0;
      end else begin
         lk_hit  <= any_hit;
         lk_miss <= !any_hit;
         if (any_hit) begin
            lk_target <= ctrl_a[sel_idx].tgt;
            lk_attr   <= ctrl_a[sel_idx].attr;
            lk_xaddr  <= {up_a[sel_idx], lk_addr[GRAN_W-1:0]};
         end else begin
            lk_target <= '0;
            lk_attr   <= '0;
            lk_xaddr  <= '0;
         end
      end
   end

endmodule

// File: rtl/adw_xlate_chk.sv
module adw_xlate_chk #(
   parameter int NUM_WIN = 14,
   localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [11:0]        cfg_addr,
   input logic [31:0]        cfg_rdata,
   input logic [31:0]        lk_addr,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic [3:0]         lk_target,
   input logic [7:0]         lk_attr,
   input logic [31:0]        lk_xaddr,
   input logic [NUM_WIN-1:0] hit_vec,
   input logic [IW-1:0]      sel_idx
);

   logic [NUM_WIN-1:0] below_sel;
   assign below_sel = (NUM_WIN'(1) << sel_idx) - NUM_WIN'(1);

   // R10
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (!lk_hit && lk_target == 4'd0 && lk_attr == 8'd0 && lk_xaddr == 32'd0));

   // R12
   low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_xaddr[15:0] == $past(lk_addr[15:0])));

   // R3
   half_reg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr[3:2] == 2'd1 || cfg_addr[3:2] == 2'd2) |-> (cfg_rdata[15:0] == 16'd0));

   // R3
   ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr[3:2] == 2'd0) |-> (cfg_rdata[3:1] == 3'd0));

   // R9
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |-> (hit_vec[sel_idx] && ((hit_vec & below_sel) == '0)));

   // R11
   hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> lk_hit);

   // R11
   miss_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|hit_vec) |=> lk_miss);

endmodule

bind addr_window_xlate adw_xlate_chk #(.NUM_WIN(NUM_WIN)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .lk_addr   (lk_addr),
   .lk_hit    (lk_hit),
   .lk_miss   (lk_miss),
   .lk_target (lk_target),
   .lk_attr   (lk_attr),
   .lk_xaddr  (lk_xaddr),
   .hit_vec   (hit_vec),
   .sel_idx   (sel_idx)
);

// File: tb/addr_window_xlate_tb_top.sv
module addr_window_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] lk_addr = '0;
   logic        lk_hit, lk_miss;
   logic [3:0]  lk_target;
   logic [7:0]  lk_attr;
   logic [31:0] lk_xaddr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_ctrl [14];
   logic [31:0] m_base [14];
   logic [31:0] m_rmlo [14];
   logic [31:0] m_rmhi [14];

   always #4 clk = ~clk;

   addr_window_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_target(lk_target),
      .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
   );

   function automatic logic [11:0] offs(input int w, input int r);
      if (w < 8) return 12'(w * 16 + r * 4);
      return 12'(12'h900 + (w - 8) * 16 + r * 4);
   endfunction

   function automatic logic [31:0] model_read(input int w, input int r);
      case (r)
         0: return m_ctrl[w];
         1: return m_base[w];
         2: return (w < 8) ? m_rmlo[w] : 32'd0;
         default: return (w < 8) ? m_rmhi[w] : 32'd0;
      endcase
   endfunction

   task automatic model_lookup(input logic [31:0] a, output logic hit,
                               output logic [3:0] tg, output logic [7:0] at,
                               output logic [31:0] xa);
      hit = 1'b0; tg = '0; at = '0; xa = '0;
      for (int w = 0; w < 14; w++) begin
         logic [15:0] m;
         m = m_ctrl[w][31:16];
         if (!hit && m_ctrl[w][0] && ((a[31:16] & ~m) == (m_base[w][31:16] & ~m))) begin
            hit = 1'b1;
            tg  = m_ctrl[w][7:4];
            at  = m_ctrl[w][15:8];
            if (w < 8) xa = {(m_rmlo[w][31:16] & ~m) | (a[31:16] & m), a[15:0]};
            else       xa = a;
         end
      end
   endtask

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input int w, input int r, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = offs(w, r); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (r)
         0: m_ctrl[w] = d & 32'hFFFF_FFF1;
         1: m_base[w] = d & 32'hFFFF_0000;
         2: if (w < 8) m_rmlo[w] = d & 32'hFFFF_0000;
         default: if (w < 8) m_rmhi[w] = d;
      endcase
   endtask

   task automatic rd_chk(input string tag, input int w, input int r);
      @(negedge clk);
      cfg_addr = offs(w, r);
      #1 check32(tag, cfg_rdata, model_read(w, r));
   endtask

   task automatic look(input string tag, input logic [31:0] a);
      logic h; logic [3:0] tg; logic [7:0] at; logic [31:0] xa;
      model_lookup(a, h, tg, at, xa);
      @(negedge clk);
      lk_addr = a;
      @(negedge clk);
      check32({tag, " hit"}, {31'd0, lk_hit}, {31'd0, h});
      check32({tag, " miss"}, {31'd0, lk_miss}, {31'd0, !h});
      check32({tag, " target"}, {28'd0, lk_target}, {28'd0, tg});
      check32({tag, " attr"}, {24'd0, lk_attr}, {24'd0, at});
      check32({tag, " xaddr"}, lk_xaddr, xa);
   endtask

   task automatic clear_all();
      for (int w = 0; w < 14; w++)
         for (int r = 0; r < 4; r++) wr(w, r, 32'd0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      for (int w = 0; w < 14; w++) begin
         m_ctrl[w] = '0; m_base[w] = '0; m_rmlo[w] = '0; m_rmhi[w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check32("R1 lk_miss after reset", {31'd0, lk_miss}, 32'd1);
      check32("R1 lk_hit after reset", {31'd0, lk_hit}, 32'd0);
      for (int w = 0; w < 14; w++)
         for (int r = 0; r < 4; r++) rd_chk("R1 reset readback", w, r);
      look("R1 R10 lookup after reset", 32'h1234_5678);

      // R2 R3 R4: layout, masking, missing remap registers
      for (int r = 0; r < 4; r++) begin
         wr(3, r, 32'hFFFF_FFFF);
         wr(10, r, 32'hFFFF_FFFF);
      end
      for (int r = 0; r < 4; r++) begin
         rd_chk("R2 R3 window 3 readback", 3, r);
         rd_chk("R2 R4 window 10 readback", 10, r);
      end
      rd_chk("R2 neighbour window 2 untouched", 2, 0);
      rd_chk("R2 neighbour window 11 untouched", 11, 1);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 12'h0F0; cfg_wdata = 32'hDEAD_BEEF;
      @(negedge clk); cfg_we = 1'b0;
      #1 check32("R4 unmapped offset reads zero", cfg_rdata, 32'd0);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 12'h031; cfg_wdata = 32'hDEAD_BEEF;
      @(negedge clk); cfg_we = 1'b0;
      #1 check32("R4 misaligned offset reads zero", cfg_rdata, 32'd0);
      rd_chk("R4 misaligned write left window 3 control", 3, 0);
      clear_all();

      // R5 R9: overlap, lowest window wins
      wr(5, 1, 32'h1000_0000); wr(5, 2, 32'h1000_0000); wr(5, 0, 32'h0000_5A51);
      wr(2, 1, 32'h1000_0000); wr(2, 2, 32'h8000_0000); wr(2, 3, 32'hFFFF_FFFF);
      wr(2, 0, 32'h000F_3C21);
      look("R9 overlap picks window 2", 32'h1000_1234);
      // R7: remap with a 16-unit window, remap high ignored
      look("R7 remapped hit", 32'h1003_ABCD);
      look("R5 outside window 2 mask", 32'h1010_0000);
      // R6: disabling window 2 exposes window 5
      wr(2, 0, 32'h0000_0000);
      look("R6 R9 disabled window skipped", 32'h1000_1234);
      wr(5, 0, 32'h0000_5A50);
      look("R6 enable bit clear never hits", 32'h1000_1234);

      // R8: fixed window passes the address through
      wr(12, 1, 32'h2000_0000); wr(12, 2, 32'h9000_0000);
      wr(12, 0, 32'h00FF_77C1);
      look("R8 fixed window passthrough", 32'h20AB_1111);
      look("R10 miss", 32'hF000_0000);

      // R11: output holds until the next edge
      look("R11 prime hit", 32'h2001_0002);
      @(negedge clk); lk_addr = 32'hF000_0000;
      #1 check32("R11 output held before edge", {31'd0, lk_hit}, 32'd1);
      @(negedge clk);
      check32("R11 output updates after edge", {31'd0, lk_miss}, 32'd1);
      clear_all();

      // Random programming and lookups (R5 R7 R8 R9 R10 R12)
      for (int pass = 0; pass < 4; pass++) begin
         for (int w = 0; w < 14; w++) begin
            logic [15:0] m;
            m = 16'((32'd1 << ($urandom % 7)) - 1);
            wr(w, 1, {16'h0100 * 16'($urandom % 4) | 16'($urandom % 64) & ~m, 16'($urandom)});
            wr(w, 2, $urandom);
            wr(w, 0, {m, 8'($urandom), 4'($urandom), 3'($urandom), 1'(($urandom % 4) != 0)});
         end
         for (int r = 0; r < 8; r++) rd_chk("R3 random readback", $urandom % 14, $urandom % 4);
         for (int k = 0; k < 100; k++) begin
            logic [31:0] a;
            int w;
            w = $urandom % 14;
            a = $urandom;
            if (($urandom % 4) != 0)
               a[31:16] = m_base[w][31:16] | (16'($urandom) & m_ctrl[w][31:16]);
            look("R5 R7 R8 R9 R12 random lookup", a);
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule